// File: doc/BRIEF.md
# System Reset Sequencer with Cause Capture

This block is the central reset source of the chip. It watches four triggers: an active-low power-on pin, an active-low reset-button pin, a software request written through its register interface, and a one-cycle timeout strobe from an external watchdog counter. Any trigger drives the internal system reset low. The reset is held while a pin stays asserted and is released a fixed number of clock cycles after the last trigger, on a clock edge.

For every reset event the block records which trigger caused it in a two-bit cause register. Software reads this register after it boots. The power-on pin is the only thing that returns the cause register to its default. The system reset that the register records does not clear it, so the value survives for software to read. When several triggers fall in one event, the cause register keeps the highest code seen. It does not matter whether they arrive in the same cycle or in different ones.

A second output holds external peripherals in reset. Every hardware reset sets it. It is then released only by a software write, and software can assert it again through its own bit. The register interface is word-addressed with byte offsets. It has a write-only control word at offset 0x000 and a read-only cause word at offset 0x004. Reads have no latency.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` and `periph_rst_n` are low and the cause reads 2'b10. After `por_n` rises, `sys_rst_n` stays low for exactly 16 more cycles and then rises.
- R2: Writing 1 to bit 2 of the control word (offset 0x000) drives `sys_rst_n` low from the next cycle for exactly 16 cycles. The cause becomes 2'b01, and `periph_rst_n` is not changed.
- R3: A one-cycle `wdt_timeout` pulse drives `sys_rst_n` low for exactly 16 cycles. It sets the cause to 2'b11 and drives `periph_rst_n` low.
- R4: While `rst_btn_n` is low, `sys_rst_n` stays low. It rises 16 cycles after the pin is released. The cause becomes 2'b00 and `periph_rst_n` is driven low.
- R5: Triggers active in the same cycle record the highest code, using watchdog 11 > power-on 10 > software 01 > pin 00. For example, button with watchdog reads 11, and button with software reads 01.
- R6: Within one reset event, a trigger arriving later keeps the larger of the stored code and its own code, and it restarts the 16-cycle count. The first trigger after `sys_rst_n` has risen replaces the stored code.
- R7: The cause register is not cleared by the system reset it records. Only `por_n` loads its default of 2'b10.
- R8: Writing 1 to control bit 0 drives `periph_rst_n` low on the next cycle, and writing 1 to bit 1 drives it high. If both bits are 1, the output goes low. Zero bits have no effect.
- R9: Control bits 31:3 are ignored on write. A read of offset 0x000 returns zero, and bits 31:2 of the cause word read as zero.
- R10: Writes to the cause offset 0x004 change neither the cause nor any reset output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset pin, active low, already synchronous to `clk` |
| rst_btn_n | input | 1 | External reset button pin, active low, already synchronous |
| wdt_timeout | input | 1 | One-cycle watchdog expiry strobe |
| reg_addr | input | 12 | Byte offset of the accessed word |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for `reg_addr`, combinational |
| sys_rst_n | output | 1 | Internal system reset, active low |
| periph_rst_n | output | 1 | External peripheral reset, active low |

## Verification
Assertions check the stretch counter on every cycle: a trigger reloads it, and it then counts down by one each cycle to idle. They also check that, inside an event, the cause is stable or only rises, that a watchdog pulse always leaves code 11, and that assert wins over release on the peripheral line. Only the bench scenarios show the following: the exact 16-cycle length seen at the output pin, the cause surviving a recorded reset, the replacement on a new event, and the reads of reserved and write-only locations.

// File: rtl/rst_ctrl_pkg.sv
// Package: shared cause codes and control-bit positions for the reset
// sequencer. Assumes the cause is a plain 2-bit number whose value is its rank.
package rst_ctrl_pkg;
    localparam logic [1:0] CAUSE_PIN   = 2'b00;
    localparam logic [1:0] CAUSE_SOFT  = 2'b01;
    localparam logic [1:0] CAUSE_POWER = 2'b10;
    localparam logic [1:0] CAUSE_WDOG  = 2'b11;

    localparam int CTRL_ASSERT_BIT  = 0;
    localparam int CTRL_RELEASE_BIT = 1;
    localparam int CTRL_SOFT_BIT    = 2;
endpackage

// File: rtl/rst_ctrl_regif.sv
// Register decode: turns writes to the control word into one-cycle request
// pulses and muxes the cause word onto the read bus. Assumes one write strobe
// per access. The control word is write-only and reads back as zero.
module rst_ctrl_regif
    import rst_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h000,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 'h004
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cause,
    output logic              soft_req,
    output logic              periph_set,
    output logic              periph_clr,
    output logic [DATA_W-1:0] rd_data
);
    logic ctrl_wr;

    // Purpose: decode a control write into its three request pulses.
    always_comb begin
        ctrl_wr    = wr_en && (addr == CTRL_OFS);
        soft_req   = ctrl_wr && wr_data[CTRL_SOFT_BIT];
        periph_set = ctrl_wr && wr_data[CTRL_ASSERT_BIT];
        periph_clr = ctrl_wr && wr_data[CTRL_RELEASE_BIT];
    end

    // Purpose: read mux; only the cause word returns data.
    always_comb begin
        rd_data = '0;
        if (addr == CAUSE_OFS) begin
            rd_data[1:0] = cause;
        end
    end
endmodule

// File: rtl/rst_ctrl_stretch.sv
// Reset stretcher: any trigger reloads a down-counter to STRETCH_CYCLES. The
// system reset is active while the counter is non-zero, so it is released on
// a clock edge STRETCH_CYCLES cycles after the last trigger. The power-on
// reset also loads the count.
module rst_ctrl_stretch #(
    parameter int STRETCH_CYCLES = 16,
    localparam int CNT_W = $clog2(STRETCH_CYCLES + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic trigger,
    output logic in_reset
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Purpose: reload on trigger or power-on, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt <= LOAD;
        end else if (trigger) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign in_reset = (cnt != '0);

    p_reload_r2: assert property (@(posedge clk) disable iff (!por_n)
        trigger |=> cnt == LOAD);
    p_countdown_r4: assert property (@(posedge clk) disable iff (!por_n)
        (in_reset && !trigger) |=> cnt == $past(cnt) - CNT_W'(1));
    p_idle_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!in_reset && !trigger) |=> !in_reset);
endmodule

// File: rtl/rst_ctrl_cause.sv
// Cause capture: ranks the triggers of this cycle and stores the result in the
// cause register. Inside a running event it keeps the larger of the stored and
// the new code; a trigger after the event has ended replaces it. Only the
// power-on reset loads the default, so the register survives the system reset.
module rst_ctrl_cause
    import rst_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       in_reset,
    input  logic       pin_req,
    input  logic       soft_req,
    input  logic       wdog_req,
    output logic [1:0] cause
);
    logic       req_any;
    logic [1:0] req_code;

    // Purpose: fixed-priority encode of the triggers active this cycle.
    always_comb begin
        req_any = pin_req || soft_req || wdog_req;
        if (wdog_req) begin
            req_code = CAUSE_WDOG;
        end else if (soft_req) begin
            req_code = CAUSE_SOFT;
        end else begin
            req_code = CAUSE_PIN;
        end
    end

    // Purpose: store a new cause or upgrade the one held for this event.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause <= CAUSE_POWER;
        end else if (req_any) begin
            if (!in_reset || (req_code > cause)) begin
                cause <= req_code;
            end
        end
    end

    p_hold_in_event_r6: assert property (@(posedge clk) disable iff (!por_n)
        (in_reset && !pin_req && !soft_req && !wdog_req) |=> $stable(cause));
    p_rank_rises_r6: assert property (@(posedge clk) disable iff (!por_n)
        in_reset |=> cause >= $past(cause));
    p_wdog_top_r5: assert property (@(posedge clk) disable iff (!por_n)
        wdog_req |=> cause == CAUSE_WDOG);
endmodule

// File: rtl/rst_ctrl_periph.sv
// External peripheral reset latch: any hardware reset or a software assert
// drives it active; a software release frees it only when no assert is
// present in the same cycle. Power-on leaves it asserted.
module rst_ctrl_periph (
    input  logic clk,
    input  logic por_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic periph_rst_n
);
    // Purpose: set/clear latch with assert taking precedence.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            periph_rst_n <= 1'b0;
        end else if (hw_set || sw_set) begin
            periph_rst_n <= 1'b0;
        end else if (sw_clr) begin
            periph_rst_n <= 1'b1;
        end
    end

    p_assert_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
        (sw_set && sw_clr) |=> !periph_rst_n);
    p_hw_asserts_r4: assert property (@(posedge clk) disable iff (!por_n)
        hw_set |=> !periph_rst_n);
    p_quiet_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!hw_set && !sw_set && !sw_clr) |=> $stable(periph_rst_n));
endmodule

// File: rtl/rst_ctrl.sv
// Top of the reset sequencer. Assumes all pins are already synchronous to
// clk and that the watchdog strobe is one cycle wide. Power-on acts as the
// synchronous active-low reset of every register in the block.
module rst_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int STRETCH_CYCLES = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_btn_n,
    input  logic              wdt_timeout,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              sys_rst_n,
    output logic              periph_rst_n
);
    logic       pin_req;
    logic       soft_req;
    logic       periph_set;
    logic       periph_clr;
    logic       in_reset;
    logic [1:0] cause;

    assign pin_req   = !rst_btn_n;
    assign sys_rst_n = !in_reset;

    rst_ctrl_regif #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_OFS  (ADDR_W'('h000)),
        .CAUSE_OFS (ADDR_W'('h004))
    ) u_regif (
        .addr       (reg_addr),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .cause      (cause),
        .soft_req   (soft_req),
        .periph_set (periph_set),
        .periph_clr (periph_clr),
        .rd_data    (reg_rd_data)
    );

    rst_ctrl_stretch #(
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk      (clk),
        .por_n    (por_n),
        .trigger  (pin_req || soft_req || wdt_timeout),
        .in_reset (in_reset)
    );

    rst_ctrl_cause u_cause (
        .clk      (clk),
        .por_n    (por_n),
        .in_reset (in_reset),
        .pin_req  (pin_req),
        .soft_req (soft_req),
        .wdog_req (wdt_timeout),
        .cause    (cause)
    );

    rst_ctrl_periph u_periph (
        .clk          (clk),
        .por_n        (por_n),
        .hw_set       (pin_req || wdt_timeout),
        .sw_set       (periph_set),
        .sw_clr       (periph_clr),
        .periph_rst_n (periph_rst_n)
    );
endmodule

// File: tb/rst_ctrl_bench.sv
module rst_ctrl_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_btn_n = 1'b1;
    logic        wdt_timeout = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        sys_rst_n;
    logic        periph_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rst_ctrl u_rst_ctrl (
        .clk(clk), .por_n(por_n), .rst_btn_n(rst_btn_n), .wdt_timeout(wdt_timeout),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .sys_rst_n(sys_rst_n), .periph_rst_n(periph_rst_n)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; one write strobe across the next posedge.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rd_data;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!sys_rst_n && n < 100) begin
            n++;
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic pulse_wdt();
        wdt_timeout = 1'b1; @(posedge clk); @(negedge clk); wdt_timeout = 1'b0;
    endtask

    task automatic read_cause(string req, logic [1:0] exp);
        logic [31:0] d;
        rd(12'h004, d);
        check(req, "cause word", d, {30'b0, exp});
    endtask

    task automatic t_power_on();
        int n;
        repeat (4) @(negedge clk);
        check("R1", "sys_rst_n in por", sys_rst_n, 1'b0);
        check("R1", "periph in por", periph_rst_n, 1'b0);
        read_cause("R1", 2'b10);
        por_n = 1'b1;
        measure_low(n);
        check("R1", "stretch after por", n, 16);
    endtask

    task automatic t_periph_ctrl();
        wr(12'h000, 32'h2);
        check("R8", "release", periph_rst_n, 1'b1);
        wr(12'h000, 32'h0);
        check("R8", "zero write", periph_rst_n, 1'b1);
        wr(12'h000, 32'h1);
        check("R8", "assert", periph_rst_n, 1'b0);
        wr(12'h000, 32'h2);
        wr(12'h000, 32'h3);
        check("R8", "assert wins", periph_rst_n, 1'b0);
        wr(12'h000, 32'h2);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(12'h000, 32'hFFFF_FFF8);
        repeat (3) @(negedge clk);
        check("R9", "reserved write sys", sys_rst_n, 1'b1);
        check("R9", "reserved write periph", periph_rst_n, 1'b1);
        rd(12'h000, d);
        check("R9", "ctrl read zero", d, 32'h0);
        read_cause("R9", 2'b10);
        wr(12'h004, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        check("R10", "cause write sys", sys_rst_n, 1'b1);
        check("R10", "cause write periph", periph_rst_n, 1'b1);
        read_cause("R10", 2'b10);
    endtask

    task automatic t_soft();
        int n;
        wr(12'h000, 32'h4);
        measure_low(n);
        check("R2", "soft stretch", n, 16);
        check("R2", "periph untouched", periph_rst_n, 1'b1);
        read_cause("R7", 2'b01);
    endtask

    task automatic t_wdog();
        int n;
        pulse_wdt();
        measure_low(n);
        check("R3", "wdog stretch", n, 16);
        check("R3", "periph asserted", periph_rst_n, 1'b0);
        read_cause("R3", 2'b11);
        wr(12'h000, 32'h2);
    endtask

    task automatic t_button();
        int n;
        rst_btn_n = 1'b0;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        check("R4", "held while pin low", sys_rst_n, 1'b0);
        rst_btn_n = 1'b1;
        measure_low(n);
        check("R4", "stretch after pin", n, 16);
        check("R4", "periph asserted", periph_rst_n, 1'b0);
        read_cause("R4", 2'b00);
        wr(12'h000, 32'h2);
    endtask

    task automatic t_same_cycle();
        int n;
        rst_btn_n = 1'b0; wdt_timeout = 1'b1;
        @(posedge clk); @(negedge clk);
        rst_btn_n = 1'b1; wdt_timeout = 1'b0;
        measure_low(n);
        check("R5", "pin+wdog stretch", n, 16);
        read_cause("R5", 2'b11);
        rst_btn_n = 1'b0;
        wr(12'h000, 32'h4);
        rst_btn_n = 1'b1;
        measure_low(n);
        read_cause("R5", 2'b01);
        wr(12'h000, 32'h2);
    endtask

    task automatic t_staggered();
        int n;
        pulse_wdt();
        repeat (3) @(negedge clk);
        rst_btn_n = 1'b0; @(posedge clk); @(negedge clk); rst_btn_n = 1'b1;
        measure_low(n);
        check("R6", "restart on later trigger", n, 16);
        read_cause("R6", 2'b11);
        wr(12'h000, 32'h2);
        wr(12'h000, 32'h4);
        repeat (3) @(negedge clk);
        pulse_wdt();
        measure_low(n);
        read_cause("R6", 2'b11);
        rst_btn_n = 1'b0; @(posedge clk); @(negedge clk); rst_btn_n = 1'b1;
        measure_low(n);
        read_cause("R6", 2'b00);
        wr(12'h000, 32'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_periph_ctrl();
        t_reserved();
        t_soft();
        t_wdog();
        t_button();
        t_same_cycle();
        t_staggered();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule